// File: doc/BRIEF.md
# Byte Serializer/Deserializer with Loopback Routing

This block sits between a byte-wide parallel interface and a single-bit serial line, all in one bit-rate clock domain. A free-running phase counter divides the bit clock by the byte width and raises a one-cycle byte strobe. At the end of each strobe cycle, a transmit byte and its parity bit are taken in. The byte is then shifted onto the serial output, most significant bit first. In the other direction, serial bits are gathered into bytes. Each byte is presented with a generated parity bit and a one-cycle valid pulse.

Three control inputs reroute the data for test. The line-side loop sends received serial data straight back out on the transmit pin after a short fixed delay. The internal loop feeds the serializer stream into the deserializer. The pin-side loop feeds the deserializer from the transmit pin itself. The line-side loop and the internal loop can be set together to give a split routing. A transmit parity mismatch is flagged one byte period after the byte that caused it.

Top module: `byte_serdes_lb`

## Requirements
- R1: While `rst_n` is low and right after it, `tx_perr`, `rx_byte`, `rx_par` and `rx_valid` are 0. `byte_stb` is first high in the 8th cycle after reset release (count 7 from 0).
- R2: `byte_stb` is high for exactly one cycle in every W (=8) cycles.
- R3: `tx_byte` is captured at the clock edge that ends a `byte_stb` cycle. With `fac_lb`=0, `tx_ser` then shows bit 7 down to bit 0 of that byte in the following 8 cycles, one bit per cycle.
- R4: The deserializer input is sampled at every edge. The bit sampled at the edge ending the cycle after a strobe cycle lands in `rx_byte` bit 7, and the bit sampled at the next strobe edge lands in bit 0. The byte appears on `rx_byte` at that strobe edge, and `rx_valid` is high for exactly the cycle that follows. With no loop control set, the deserializer input is `rx_ser`.
- R5: While `rx_valid` is high, `rx_par` is 1 when `rx_byte` has an odd number of ones and 0 otherwise. It is held with the byte.
- R6: `tx_perr` changes only at strobe edges. After a strobe edge it shows the error of the byte captured at the previous strobe edge. The error is 1 when `tx_par` differs from the XOR of all bits of that byte.
- R7: With `fac_lb`=1, `tx_ser` equals `rx_ser` as sampled 2 clock edges earlier. With `eq_lb`=0 and `hs_lb`=0, the deserializer still takes `rx_ser`.
- R8: With `eq_lb`=1, the deserializer takes the serializer stream instead of `rx_ser`, so each transmit byte appears on `rx_byte` one strobe later. With `fac_lb`=0, `tx_ser` still carries the serializer stream.
- R9: With `fac_lb`=1 and `eq_lb`=1 (split), `tx_ser` follows `rx_ser` as in R7, while `rx_byte` returns the transmit bytes as in R8.
- R10: With `hs_lb`=1 and `eq_lb`=0, the deserializer takes the value on the `tx_ser` pin. With `fac_lb`=0, transmit bytes therefore return on `rx_byte` one strobe later. `eq_lb` takes priority over `hs_lb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_byte | input | W | Parallel transmit byte |
| tx_par | input | 1 | Transmit parity bit for `tx_byte` |
| rx_ser | input | 1 | Serial line input |
| fac_lb | input | 1 | Line-side loop: line input to transmit pin |
| eq_lb | input | 1 | Internal loop: serializer stream to deserializer |
| hs_lb | input | 1 | Pin-side loop: transmit pin to deserializer |
| byte_stb | output | 1 | Byte strobe, high in the last bit cycle of a byte |
| tx_ser | output | 1 | Serial transmit output |
| tx_perr | output | 1 | Transmit parity error, one byte period late |
| rx_byte | output | W | Assembled receive byte |
| rx_par | output | 1 | Parity of `rx_byte` (1 for odd count of ones) |
| rx_valid | output | 1 | One-cycle pulse when a new `rx_byte` is presented |

## Verification
The bench builds the block with its default byte width of 8. This keeps the whole transmit value space small enough to sweep: every one of the 256 byte values is sent with both correct and corrupted parity, so every parity outcome and bit order is seen. A small byte width also means each loopback routing can be run for dozens of byte periods in a few thousand cycles. The two-edge line-loop delay and the byte alignment of the deserializer are therefore checked bit by bit across mode switches.

// File: rtl/byte_serdes_pkg.sv
// Shared definitions for the byte serializer/deserializer.
// Assumes a single bit-rate clock domain.
package byte_serdes_pkg;

    // Number of flops between the line input and the transmit pin in line-side loop.
    localparam int FAC_STAGES = 2;

    // Source feeding the deserializer.
    typedef enum logic [1:0] {
        SRC_LINE     = 2'd0,   // serial line input
        SRC_SER_INT  = 2'd1,   // serializer stream, inside the block
        SRC_TX_PIN   = 2'd2    // value driven on the transmit pin
    } des_src_e;

endpackage

// File: rtl/bit_phase_ctr.sv
// Bit-phase counter: divides the bit clock by W and raises a strobe in the
// last bit cycle of each byte. Assumes W >= 2.
module bit_phase_ctr #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic stb
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] phase;

    // Advance the bit phase, wrapping after the last bit of a byte.
    always_ff @(posedge clk) begin
        if (!rst_n)              phase <= '0;
        else if (phase == LAST)  phase <= '0;
        else                     phase <= phase + CW'(1);
    end

    assign stb = (phase == LAST);
endmodule

// File: rtl/tx_serializer.sv
// Transmit serializer: loads the parallel byte at the end of a strobe cycle,
// shifts it out MSB first, and reports a parity mismatch one strobe later.
// Assumes the caller holds tx_byte/tx_par valid in the strobe cycle.
module tx_serializer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic [W-1:0] tx_byte,
    input  logic         tx_par,
    output logic         ser_bit,
    output logic         perr
);
    logic [W-1:0] shreg;
    logic         err_pend;

    // Load on the strobe edge, otherwise shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)   shreg <= '0;
        else if (stb) shreg <= tx_byte;
        else          shreg <= {shreg[W-2:0], 1'b0};
    end

    // Capture the mismatch now and publish it at the following strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pend <= 1'b0;
            perr     <= 1'b0;
        end else if (stb) begin
            err_pend <= (^tx_byte) ^ tx_par;
            perr     <= err_pend;
        end
    end

    assign ser_bit = shreg[W-1];
endmodule

// File: rtl/lb_router.sv
// Loopback router: picks what drives the transmit pin and what feeds the
// deserializer. The line input passes through a short flop chain so that
// the line-side loop has a fixed delay.
module lb_router
    import byte_serdes_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_ser,
    input  logic ser_bit,
    input  logic fac_lb,
    input  logic eq_lb,
    input  logic hs_lb,
    output logic tx_ser,
    output logic des_in
);
    logic [FAC_STAGES-1:0] line_dly;
    des_src_e              src;

    // Stage the line input through the delay chain.
    generate
        for (genvar s = 0; s < FAC_STAGES; s++) begin : g_dly
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) line_dly[0] <= 1'b0;
                    else        line_dly[0] <= rx_ser;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) line_dly[s] <= 1'b0;
                    else        line_dly[s] <= line_dly[s-1];
                end
            end
        end
    endgenerate

    // Transmit pin: delayed line data in line-side loop, else the serializer.
    assign tx_ser = fac_lb ? line_dly[FAC_STAGES-1] : ser_bit;

    // Deserializer source: the internal loop wins over the pin loop.
    always_comb begin
        if (eq_lb)      src = SRC_SER_INT;
        else if (hs_lb) src = SRC_TX_PIN;
        else            src = SRC_LINE;
    end

    // Route the chosen source to the deserializer.
    always_comb begin
        case (src)
            SRC_SER_INT: des_in = ser_bit;
            SRC_TX_PIN:  des_in = tx_ser;
            default:     des_in = rx_ser;
        endcase
    end
endmodule

// File: rtl/rx_deserializer.sv
// Receive deserializer: shifts in one bit per clock (first bit ends in the
// MSB) and presents the assembled byte with its parity at each strobe edge.
// Assumes W >= 2 and the same strobe as the serializer.
module rx_deserializer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic         din,
    output logic [W-1:0] rx_byte,
    output logic         rx_par,
    output logic         rx_valid
);
    logic [W-1:0] asm_q;
    logic [W-1:0] next_byte;

    assign next_byte = {asm_q[W-2:0], din};

    // Gather serial bits continuously.
    always_ff @(posedge clk) begin
        if (!rst_n) asm_q <= '0;
        else        asm_q <= next_byte;
    end

    // Publish the byte, its parity and a valid pulse at the strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte  <= '0;
            rx_par   <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= stb;
            if (stb) begin
                rx_byte <= next_byte;
                rx_par  <= ^next_byte;
            end
        end
    end
endmodule

// File: rtl/byte_serdes_lb.sv
// Top level: byte serializer/deserializer with loopback routing.
// One bit clock; byte timing comes from an internal divide-by-W strobe.
module byte_serdes_lb #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tx_byte,
    input  logic         tx_par,
    input  logic         rx_ser,
    input  logic         fac_lb,
    input  logic         eq_lb,
    input  logic         hs_lb,
    output logic         byte_stb,
    output logic         tx_ser,
    output logic         tx_perr,
    output logic [W-1:0] rx_byte,
    output logic         rx_par,
    output logic         rx_valid
);
    logic ser_bit;
    logic des_in;

    bit_phase_ctr #(.W(W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (byte_stb)
    );

    tx_serializer #(.W(W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (byte_stb),
        .tx_byte (tx_byte),
        .tx_par  (tx_par),
        .ser_bit (ser_bit),
        .perr    (tx_perr)
    );

    lb_router u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_ser  (rx_ser),
        .ser_bit (ser_bit),
        .fac_lb  (fac_lb),
        .eq_lb   (eq_lb),
        .hs_lb   (hs_lb),
        .tx_ser  (tx_ser),
        .des_in  (des_in)
    );

    rx_deserializer #(.W(W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (byte_stb),
        .din      (des_in),
        .rx_byte  (rx_byte),
        .rx_par   (rx_par),
        .rx_valid (rx_valid)
    );
endmodule

// File: rtl/byte_serdes_lb_chk.sv
// Checker for byte_serdes_lb: port-level timing properties, bound to the top.
module byte_serdes_lb_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rx_ser,
    input logic         fac_lb,
    input logic         byte_stb,
    input logic         tx_ser,
    input logic         tx_perr,
    input logic [W-1:0] rx_byte,
    input logic         rx_par,
    input logic         rx_valid
);
    logic [1:0] warm;

    // Count edges since reset release, saturating at 2.
    always_ff @(posedge clk) begin
        if (!rst_n)            warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    a_r2_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> !byte_stb);

    a_r4_valid_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        $past(byte_stb) |-> rx_valid);

    a_r4_valid_only_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(byte_stb) |-> !rx_valid);

    a_r5_rx_parity: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (rx_par == ^rx_byte));

    a_r6_perr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(byte_stb) |-> $stable(tx_perr));

    a_r7_fac_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (fac_lb && warm == 2'd2) |-> (tx_ser == $past(rx_ser, 2)));
endmodule

bind byte_serdes_lb byte_serdes_lb_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_ser   (rx_ser),
    .fac_lb   (fac_lb),
    .byte_stb (byte_stb),
    .tx_ser   (tx_ser),
    .tx_perr  (tx_perr),
    .rx_byte  (rx_byte),
    .rx_par   (rx_par),
    .rx_valid (rx_valid)
);

// File: tb/tb_byte_serdes_lb.sv
// Self-checking bench: walks the block through every routing, byte by byte.
module tb_byte_serdes_lb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] tx_byte = '0;
    logic         tx_par = 1'b0;
    logic         rx_ser = 1'b0;
    logic         fac_lb = 1'b0;
    logic         eq_lb = 1'b0;
    logic         hs_lb = 1'b0;
    logic         byte_stb, tx_ser, tx_perr, rx_par, rx_valid;
    logic [W-1:0] rx_byte;

    int errors = 0;
    int checks = 0;

    // Bench-side expectations.
    logic [3:0]   hist = '0;
    logic [W-1:0] prev_line = '0;
    logic [W-1:0] prev_exp_rx = '0;
    logic         rx_known = 1'b1;
    logic         prev_err = 1'b0;

    always #5 clk = ~clk;

    byte_serdes_lb #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .tx_byte(tx_byte), .tx_par(tx_par),
        .rx_ser(rx_ser), .fac_lb(fac_lb), .eq_lb(eq_lb), .hs_lb(hs_lb),
        .byte_stb(byte_stb), .tx_ser(tx_ser), .tx_perr(tx_perr),
        .rx_byte(rx_byte), .rx_par(rx_par), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_rx(input logic b);
        rx_ser = b;
        hist = {hist[2:0], b};
    endtask

    // Change routing at a strobe cycle; the byte then in flight is not checked.
    task automatic set_mode(input logic f, input logic e, input logic h);
        fac_lb = f; eq_lb = e; hs_lb = h;
        rx_known = 1'b0;
    endtask

    // One byte period. Entry and exit: at a negedge inside a strobe cycle.
    task automatic do_byte(input logic [W-1:0] txb, input logic txp,
                           input logic [W-1:0] lineb);
        logic [W-1:0] exp_rx;
        logic         cur_err;
        logic         exp_tx;
        cur_err = (^txb) ^ txp;
        exp_rx  = (eq_lb || hs_lb) ? txb : lineb;
        tx_byte = txb;
        tx_par  = txp;
        drive_rx(prev_line[0]);
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            if (k == 0) begin
                chk(rx_valid == 1'b1, "R4 valid pulse", rx_valid, 1);
                if (rx_known) begin
                    chk(rx_byte == prev_exp_rx,
                        eq_lb ? "R8/R9 rx_byte" : (hs_lb ? "R10 rx_byte" : "R4/R7 rx_byte"),
                        rx_byte, prev_exp_rx);
                    chk(rx_par == ^prev_exp_rx, "R5 rx_par", rx_par, ^prev_exp_rx);
                end
            end else begin
                chk(rx_valid == 1'b0, "R4 valid single", rx_valid, 0);
            end
            chk(tx_perr == prev_err, "R6 tx_perr", tx_perr, prev_err);
            chk(byte_stb == (k == W - 1), "R2 strobe", byte_stb, (k == W - 1));
            exp_tx = fac_lb ? hist[1] : txb[W-1-k];
            chk(tx_ser == exp_tx, fac_lb ? "R7/R9 tx_ser" : "R3 tx_ser", tx_ser, exp_tx);
            if (k < W - 1) drive_rx(lineb[W-1-k]);
        end
        prev_exp_rx = exp_rx;
        rx_known    = 1'b1;
        prev_err    = cur_err;
        prev_line   = lineb;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] b;
        // R1: reset values.
        repeat (3) @(negedge clk);
        chk(tx_perr == 0, "R1 tx_perr in reset", tx_perr, 0);
        chk(rx_valid == 0, "R1 rx_valid in reset", rx_valid, 0);
        chk(rx_byte == 0, "R1 rx_byte in reset", rx_byte, 0);
        chk(rx_par == 0, "R1 rx_par in reset", rx_par, 0);
        rst_n = 1'b1;
        for (int i = 0; i < W - 1; i++) begin
            chk(byte_stb == 0, "R1 first strobe timing", byte_stb, 0);
            @(negedge clk);
        end
        chk(byte_stb == 1, "R1 first strobe timing", byte_stb, 1);

        // Normal routing: R3, R4, R5, R6.
        for (int i = 0; i < 40; i++) begin
            b = W'(i * 11 + 3);
            do_byte(b, (^b) ^ (i % 4 == 1), W'(i * 37 + 5));
        end

        // Internal loop, exhaustive over byte values and parity sense: R8, R5, R6.
        set_mode(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 512; i++) begin
            b = W'(i);
            do_byte(b, (^b) ^ (i >= 256), W'(i * 13));
        end

        // Line-side loop: R7.
        set_mode(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 40; i++) do_byte(W'(i * 7), 1'b0, W'(i * 53 + 9));

        // Split routing: R9.
        set_mode(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 40; i++) begin
            b = W'(i * 29 + 1);
            do_byte(b, ^b, W'(i * 71 + 17));
        end

        // Pin-side loop, and its priority below the internal loop: R10.
        set_mode(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 40; i++) do_byte(W'(i * 19 + 6), 1'b1, W'(i * 3 + 200));
        set_mode(1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 20; i++) do_byte(W'(i * 41 + 2), 1'b0, W'(i * 5 + 99));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule